// File: doc/BRIEF.md
# Envelope shape generator

This block produces a 5-bit amplitude that moves over time, for use as the variable level of a sound channel. A 4-bit shape code chooses the contour: a single ramp that ends in silence, a repeating sawtooth, a triangle, or a single ramp that then freezes at its top or its bottom. A 16-bit period sets how fast the ramp steps. Each step takes eight master ticks times the period, so one full 32-step ramp repeats at the master tick rate divided by 256 times the period.

The surrounding register file holds the period and the shape code. It also raises a one-cycle pulse each time software writes the shape. That pulse latches the new code and restarts the contour from its first step, which includes the step prescaler. Two status flags show whether the contour is frozen and whether the current ramp is rising.

Top module: `envelope_gen`

## Requirements
- R1: After reset, and until the first shape write, the level is 0, the hold flag is 1 and the rising flag is 0.
- R2: The shape code carries continue in bit 3, attack in bit 2, alternate in bit 1 and hold in bit 0. A shape write sets the level to 31 (attack=0) or to 0 (attack=1), clears the hold flag and sets the rising flag equal to attack. These values are visible in the cycle after the write pulse.
- R3: One step happens every 8×period master ticks. The first step is taken on the 8×period-th tick after the write pulse.
- R4: In cycles where the master tick is low, the level and the flags do not change.
- R5: A period of 0 times the steps exactly as a period of 1.
- R6: During the first ramp, each step moves the level by one toward the far end. The ramp rises from 0 to 31 when attack=1 and falls from 31 to 0 when attack=0. The ramp takes 32 steps.
- R7: With continue=0, the step after the first ramp sets the level to 0 and the hold flag to 1, whatever the other bits are.
- R8: With continue=1, alternate=0 and hold=0, the same ramp repeats with no break (sawtooth).
- R9: With continue=1, alternate=1 and hold=0, the ramp direction reverses after every 32 steps (triangle), and the rising flag follows it.
- R10: With continue=1 and hold=1, the level freezes after the first ramp. It freezes at the ramp's last value when alternate=0, and at the opposite extreme when alternate=1. The hold flag reads 1.
- R11: The rising flag is 1 exactly while the current ramp counts upward.
- R12: A shape write in the middle of a contour restarts it from its first step with the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Master tick enable |
| period_i | input | PER_W (16) | Step period; 0 is treated as 1 |
| shape_i | input | 4 | Shape code {continue, attack, alternate, hold} |
| shape_wr_i | input | 1 | One-cycle pulse on a write to the shape register |
| level_o | output | LVL_W (5) | Envelope amplitude |
| hold_o | output | 1 | Contour frozen |
| rising_o | output | 1 | Current ramp counts upward |

## Verification
All sixteen shape codes are grouped by their continue, attack, alternate and hold bits. Each group is sampled at steps inside the first ramp, on the ramp boundary and well past it. This separates a one-shot contour from a repeat, a reversal and a freeze, and shows which extreme a frozen contour keeps. Periods 0, 1, 2 and 3 are used, with a sample one tick before and one tick on a step edge, so the prescaler factor and the period-0 case are pinned down. The bench also holds the tick low for a long stretch and restarts a contour in the middle of a ramp, which shows that a write resets both the ramp position and the step timing.

// File: rtl/envgen_pkg.sv
package envgen_pkg;
  typedef struct packed {
    logic cont;   // bit 3: repeat after the first ramp
    logic att;    // bit 2: first ramp rises
    logic alt;    // bit 1: reverse direction at ramp end
    logic hold;   // bit 0: freeze after the first ramp
  } env_shape_t;
endpackage

// File: rtl/env_rst_sync.sv
module env_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/env_step_timer.sv
module env_step_timer #(
  parameter int PER_W   = 16,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [PER_W-1:0] period_i,
  output logic             step_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] eff_period;
  logic             pre_wrap;
  logic             per_last;

  // a zero period steps at the same rate as a period of one
  assign eff_period = (period_i == '0) ? PER_W'(1) : period_i;
  assign pre_wrap   = tick_i && (pre_q == PRE_LAST);
  // magnitude compare so a shortened period never overshoots the wrap
  assign per_last   = (per_q >= (eff_period - PER_W'(1)));
  assign step_o     = pre_wrap && per_last && !clr_i;

  always_comb begin
    pre_d = pre_q;
    per_d = per_q;
    if (clr_i) begin
      pre_d = '0;
      per_d = '0;
    end else if (tick_i) begin
      pre_d = pre_wrap ? '0 : pre_q + PRE_W'(1);
      if (pre_wrap) begin
        per_d = per_last ? '0 : per_q + PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      per_q <= '0;
    end else begin
      pre_q <= pre_d;
      per_q <= per_d;
    end
  end

  // R4: without a tick and without a restart the timer does not move
  assert_idle_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> ($stable(pre_q) && $stable(per_q)));

  // R3: a step is only ever issued on a master tick
  assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> tick_i);
endmodule

// File: rtl/env_shape_seq.sv
module env_shape_seq
  import envgen_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             wr_i,
  input  env_shape_t       shape_i,
  output logic [LVL_W-1:0] level_o,
  output logic             hold_o,
  output logic             rising_o
);
  localparam logic [LVL_W-1:0] CNT_MAX = {LVL_W{1'b1}};

  logic [LVL_W-1:0] cnt_q, cnt_d;
  logic             att_q, att_d;
  logic             hold_q, hold_d;
  env_shape_t       shape_q, shape_d;

  always_comb begin
    cnt_d   = cnt_q;
    att_d   = att_q;
    hold_d  = hold_q;
    shape_d = shape_q;
    if (wr_i) begin
      cnt_d   = '0;
      att_d   = shape_i.att;
      hold_d  = 1'b0;
      shape_d = shape_i;
    end else if (step_i && !hold_q) begin
      if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + LVL_W'(1);
      end else if (!shape_q.cont) begin
        // one-shot: settle at zero
        att_d  = 1'b0;
        hold_d = 1'b1;
      end else if (shape_q.hold) begin
        // freeze, optionally at the opposite extreme
        att_d  = att_q ^ shape_q.alt;
        hold_d = 1'b1;
      end else begin
        cnt_d = '0;
        att_d = att_q ^ shape_q.alt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_MAX;
      att_q   <= 1'b0;
      hold_q  <= 1'b1;
      shape_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      att_q   <= att_d;
      hold_q  <= hold_d;
      shape_q <= shape_d;
    end
  end

  assign level_o  = att_q ? cnt_q : ~cnt_q;
  assign hold_o   = hold_q;
  assign rising_o = att_q;

  // R6: inside a ramp every step advances the position by one
  assert_ramp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !wr_i && !hold_q && cnt_q != CNT_MAX) |=>
      ((cnt_q - $past(cnt_q)) == LVL_W'(1)));

  // R10: a frozen contour stays put until the next write
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wr_i) |=> ($stable(level_o) && hold_q));

  // R12: a write always restarts at the first step
  assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == '0 && !hold_q && rising_o == $past(shape_i.att)));

  // R7: a finished one-shot contour is silent
  assert_oneshot_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !shape_q.cont) |-> (level_o == '0));
endmodule

// File: rtl/envelope_gen.sv
module envelope_gen
  import envgen_pkg::*;
#(
  parameter int PER_W   = 16,
  parameter int LVL_W   = 5,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [3:0]       shape_i,
  input  logic             shape_wr_i,
  output logic [LVL_W-1:0] level_o,
  output logic             hold_o,
  output logic             rising_o
);
  logic       rst_n_int;
  logic       step;
  env_shape_t shape_code;

  assign shape_code = env_shape_t'(shape_i);

  env_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  env_step_timer #(
    .PER_W   (PER_W),
    .PRE_DIV (PRE_DIV)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tick_i   (tick_i),
    .clr_i    (shape_wr_i),
    .period_i (period_i),
    .step_o   (step)
  );

  env_shape_seq #(
    .LVL_W (LVL_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .step_i   (step),
    .wr_i     (shape_wr_i),
    .shape_i  (shape_code),
    .level_o  (level_o),
    .hold_o   (hold_o),
    .rising_o (rising_o)
  );

  // R11: while the contour runs, the level sits on the side of the ramp direction
  assert_dir_start_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    shape_wr_i |=> (level_o == (rising_o ? '0 : {LVL_W{1'b1}})));
endmodule

// File: tb/envelope_gen_tb.sv
module envelope_gen_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 18;

  typedef struct packed {
    logic [3:0]  sh;
    logic [15:0] per;
    logic [7:0]  st;
    logic [4:0]  lv;
    logic        hd;
    logic        dr;
  } vec_t;

  // shape, period, steps after write, expected level, hold, rising
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 16'd1,  8'd0, 5'd31, 1'b0, 1'b0},  // R2 decay start
    '{4'b0000, 16'd1,  8'd5, 5'd26, 1'b0, 1'b0},  // R6 falling
    '{4'b0000, 16'd1, 8'd32, 5'd0,  1'b1, 1'b0},  // R7
    '{4'b0100, 16'd1,  8'd0, 5'd0,  1'b0, 1'b1},  // R2 attack start
    '{4'b0100, 16'd1, 8'd31, 5'd31, 1'b0, 1'b1},  // R6 top of rise
    '{4'b0110, 16'd1, 8'd40, 5'd0,  1'b1, 1'b0},  // R7 attack one-shot
    '{4'b1000, 16'd1, 8'd32, 5'd31, 1'b0, 1'b0},  // R8 saw down wraps
    '{4'b1000, 16'd1, 8'd35, 5'd28, 1'b0, 1'b0},  // R8
    '{4'b1100, 16'd1, 8'd33, 5'd1,  1'b0, 1'b1},  // R8 saw up
    '{4'b1010, 16'd1, 8'd33, 5'd1,  1'b0, 1'b1},  // R9 R11 triangle turns up
    '{4'b1110, 16'd1, 8'd40, 5'd23, 1'b0, 1'b0},  // R9 R11 turns down
    '{4'b1110, 16'd1, 8'd64, 5'd0,  1'b0, 1'b1},  // R9 back up
    '{4'b1001, 16'd1, 8'd40, 5'd0,  1'b1, 1'b0},  // R10 hold low
    '{4'b1011, 16'd1, 8'd40, 5'd31, 1'b1, 1'b1},  // R10 alt hold high
    '{4'b1101, 16'd1, 8'd40, 5'd31, 1'b1, 1'b1},  // R10 hold high
    '{4'b1111, 16'd1, 8'd40, 5'd0,  1'b1, 1'b0},  // R10 alt hold low
    '{4'b1100, 16'd3, 8'd10, 5'd10, 1'b0, 1'b1},  // R3 period 3
    '{4'b1100, 16'd0, 8'd10, 5'd10, 1'b0, 1'b1}   // R5 period 0
  };

  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic [15:0] period_i;
  logic [3:0]  shape_i;
  logic        shape_wr_i;
  logic [4:0]  level_o;
  logic        hold_o;
  logic        rising_o;

  int checks;
  int fails;

  envelope_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .period_i   (period_i),
    .shape_i    (shape_i),
    .shape_wr_i (shape_wr_i),
    .level_o    (level_o),
    .hold_o     (hold_o),
    .rising_o   (rising_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [4:0] lv, input logic hd, input logic dr);
    checks++;
    if (level_o !== lv || hold_o !== hd || rising_o !== dr) begin
      fails++;
      $display("FAIL %s: level=%0d hold=%0b rising=%0b expected level=%0d hold=%0b rising=%0b",
               req, level_o, hold_o, rising_o, lv, hd, dr);
    end
  endtask

  task automatic do_write(input logic [3:0] sh, input logic [15:0] per);
    @(negedge clk);
    shape_i    = sh;
    period_i   = per;
    shape_wr_i = 1'b1;
    @(negedge clk);
    shape_wr_i = 1'b0;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      repeat (n) @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    checks     = 0;
    fails      = 0;
    rst_n      = 1'b0;
    tick_i     = 1'b1;
    period_i   = 16'd1;
    shape_i    = 4'b0000;
    shape_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset state", 5'd0, 1'b1, 1'b0);
    run(200);
    check("R1 quiet before first write", 5'd0, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      int eff;
      eff = (VECS[i].per == 16'd0) ? 1 : int'(VECS[i].per);
      do_write(VECS[i].sh, VECS[i].per);
      run(int'(VECS[i].st) * 8 * eff);
      check($sformatf("R6/R7/R8/R9/R10 vector %0d", i), VECS[i].lv, VECS[i].hd, VECS[i].dr);
    end

    // R3: exact step edge with period 2 (16 ticks per step)
    do_write(4'b1100, 16'd2);
    run(15);
    check("R3 one tick before step", 5'd0, 1'b0, 1'b1);
    run(1);
    check("R3 on step tick", 5'd1, 1'b0, 1'b1);

    // R4: ticks held low freeze everything
    @(negedge clk);
    tick_i = 1'b0;
    run(300);
    check("R4 no ticks no change", 5'd1, 1'b0, 1'b1);
    tick_i = 1'b1;
    run(15);
    check("R4 resumes after ticks", 5'd2, 1'b0, 1'b1);

    // R12: restart in mid ramp with a new code
    do_write(4'b1100, 16'd1);
    run(80);
    check("R12 before restart", 5'd10, 1'b0, 1'b1);
    do_write(4'b0000, 16'd1);
    check("R12 restart R2 decay start", 5'd31, 1'b0, 1'b0);
    run(8);
    check("R12 first step after restart", 5'd30, 1'b0, 1'b0);

    // R11: a frozen contour is rewritten into an upward ramp
    do_write(4'b1111, 16'd1);
    run(256);
    check("R11 after alt-hold freeze", 5'd0, 1'b1, 1'b0);
    do_write(4'b1100, 16'd1);
    run(24);
    check("R11 rising again", 5'd3, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule